// File: doc/BRIEF.md
# Offset Calibration Sequencer

This block sits between a two-channel decimated sample stream and the serial output stage. It owns the power-down and offset-calibration sequence. While the active-low power-down input is held low, the block blanks its output. When the input is released after a qualified low period, and calibration is enabled, the block measures the zero-input offset of each channel. It averages a fixed number of samples per channel, holds the result in a register, and raises a busy flag for the whole measurement.

Once calibration ends, one further sample period is discarded. From then on the stored offset of each channel is subtracted from every incoming sample of that channel, and the result is clamped to the signed data range. When calibration is disabled, releasing power-down clears both stored offsets and returns the block straight to normal operation. The block supplies the corrected sample pair with a valid strobe, the busy flag and a blanking signal for the serial stage.

Top module: `offset_cal_seq`

## Requirements
- R1: After reset, `blank`, `cal_busy` and `out_vld` are 0, both outputs read 0, and both stored offsets are zero, so samples pass through unchanged.
- R2: A clock edge that samples `pwr_n` low sets `blank` on that same edge. While `pwr_n` stays low, no `out_vld` is produced, both outputs read 0 and input samples are ignored.
- R3: If `pwr_n` was sampled low on at least MIN_LOW consecutive edges and `cal_dis` is 0, the edge that samples it high again sets `cal_busy`. `cal_busy` then stays high, with `blank` high and no `out_vld`, until the edge that takes the 2^CAL_LOG2-th sample strobe.
- R4: After the last calibration sample, `cal_busy` is 0 and `blank` stays 1 for one more sample strobe, whose sample is discarded. `blank` then drops and the next sample is output.
- R5: The stored offset of each channel is the sum of its calibration samples, accumulated at ACC_W bits and shifted arithmetically right by CAL_LOG2, so it rounds toward minus infinity.
- R6: In normal operation, every `smp_vld` pulse produces `out_vld` one clock later, with each output equal to that channel's input minus that channel's offset.
- R7: A difference above 2^(DATA_W-1)-1 or below -2^(DATA_W-1) is clamped to that limit instead of wrapping.
- R8: A low pulse on `pwr_n` shorter than MIN_LOW edges starts no calibration. The block goes back to normal operation and keeps both offsets.
- R9: With `cal_dis` at 1, releasing a qualified power-down raises no `cal_busy`, clears both offsets to zero and resumes normal output directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_n | input | 1 | Power-down request, active low; its release triggers calibration |
| cal_dis | input | 1 | 1 disables calibration, 0 enables it |
| smp_vld | input | 1 | One-clock strobe per sample period, qualifying both inputs |
| in_left | input | DATA_W | Left channel sample, two's complement |
| in_right | input | DATA_W | Right channel sample, two's complement |
| out_left | output | DATA_W | Corrected left sample |
| out_right | output | DATA_W | Corrected right sample |
| out_vld | output | 1 | One-clock strobe for a corrected sample pair |
| cal_busy | output | 1 | High while calibration samples are being taken |
| blank | output | 1 | High while the serial output must be forced low |

## Verification
The bench builds the block with DATA_W at 20, MIN_LOW at 2 and CAL_LOG2 reduced to 4. A calibration therefore spans 16 sample periods instead of 4096, so several complete power-down, calibration and settle sequences fit into one short run. Calibration data is chosen to produce a fractional negative average, which exercises the rounding of the arithmetic shift. Full-scale inputs against the resulting offsets drive both saturation limits. A one-clock power-down glitch and a run with calibration disabled cover the two paths that must skip measurement.

// File: rtl/ocs_pkg.sv
package ocs_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_PD     = 2'd1,
    ST_CAL    = 2'd2,
    ST_SETTLE = 2'd3
  } ocs_state_e;

  localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/ocs_pd_qual.sv
module ocs_pd_qual #(
  parameter int unsigned MIN_LOW = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_n,
  output logic rel_ok,
  output logic rel_short
);
  localparam int unsigned CNT_W = $clog2(MIN_LOW + 1);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MIN_LOW);

  logic [CNT_W-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
    end else if (pwr_n) begin
      low_cnt <= '0;
    end else if (low_cnt != CNT_SAT) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  assign rel_ok    = pwr_n && (low_cnt >= CNT_SAT);
  assign rel_short = pwr_n && (low_cnt != '0) && (low_cnt < CNT_SAT);

  // R3: a qualified release follows a low input
  a_r3_release_after_low: assert property (@(posedge clk) disable iff (rst)
    rel_ok |-> $past(!pwr_n));
endmodule

// File: rtl/ocs_ch_accum.sv
module ocs_ch_accum #(
  parameter int unsigned DATA_W   = 20,
  parameter int unsigned ACC_W    = 32,
  parameter int unsigned CAL_LOG2 = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     add,
  input  logic                     last,
  input  logic                     clr_off,
  input  logic signed [DATA_W-1:0] din,
  output logic signed [DATA_W-1:0] offset
);
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] acc_nxt;
  logic signed [ACC_W-1:0] avg;

  always_comb begin
    acc_nxt = acc + ACC_W'(din);
    avg     = acc_nxt >>> CAL_LOG2;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc <= '0;
    end else if (add) begin
      acc <= last ? '0 : acc_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_off) begin
      offset <= '0;
    end else if (add && last) begin
      offset <= avg[DATA_W-1:0];
    end
  end

  // R5: the sum restarts once an average has been stored
  a_r5_acc_restart: assert property (@(posedge clk) disable iff (rst)
    (add && last) |=> (acc == '0));
  // R9: a clear request leaves a zero offset
  a_r9_offset_cleared: assert property (@(posedge clk) disable iff (rst)
    clr_off |=> (offset == '0));
endmodule

// File: rtl/ocs_ch_correct.sv
module ocs_ch_correct #(
  parameter int unsigned DATA_W = 20
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     pass,
  input  logic                     smp_vld,
  input  logic signed [DATA_W-1:0] din,
  input  logic signed [DATA_W-1:0] offset,
  output logic signed [DATA_W-1:0] dout
);
  localparam logic signed [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [DATA_W:0]   diff;
  logic signed [DATA_W-1:0] clamped;

  always_comb begin
    diff = {din[DATA_W-1], din} - {offset[DATA_W-1], offset};
    if (!diff[DATA_W] && diff[DATA_W-1]) begin
      clamped = MAX_V;
    end else if (diff[DATA_W] && !diff[DATA_W-1]) begin
      clamped = MIN_V;
    end else begin
      clamped = diff[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !pass) begin
      dout <= '0;
    end else if (smp_vld) begin
      dout <= clamped;
    end
  end

  // R7: full-scale input against a negative offset clamps high
  a_r7_clamp_high: assert property (@(posedge clk) disable iff (rst)
    (pass && smp_vld && din == MAX_V && offset[DATA_W-1]) |=> (dout == MAX_V));
  // R7: most negative input against a positive offset clamps low
  a_r7_clamp_low: assert property (@(posedge clk) disable iff (rst)
    (pass && smp_vld && din == MIN_V && !offset[DATA_W-1] && offset != '0)
    |=> (dout == MIN_V));
endmodule

// File: rtl/offset_cal_seq.sv
module offset_cal_seq
  import ocs_pkg::*;
#(
  parameter int unsigned DATA_W   = 20,
  parameter int unsigned ACC_W    = 32,
  parameter int unsigned CAL_LOG2 = 12,
  parameter int unsigned MIN_LOW  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     pwr_n,
  input  logic                     cal_dis,
  input  logic                     smp_vld,
  input  logic signed [DATA_W-1:0] in_left,
  input  logic signed [DATA_W-1:0] in_right,
  output logic signed [DATA_W-1:0] out_left,
  output logic signed [DATA_W-1:0] out_right,
  output logic                     out_vld,
  output logic                     cal_busy,
  output logic                     blank
);
  localparam logic [CAL_LOG2-1:0] CNT_LAST = {CAL_LOG2{1'b1}};

  ocs_state_e state, state_nxt;
  logic [CAL_LOG2-1:0] smp_cnt;
  logic rel_ok, rel_short;
  logic acc_add, acc_last, acc_clr, off_clr, pass;

  logic signed [DATA_W-1:0] din_ch  [NUM_CH];
  logic signed [DATA_W-1:0] off_ch  [NUM_CH];
  logic signed [DATA_W-1:0] dout_ch [NUM_CH];

  ocs_pd_qual #(.MIN_LOW(MIN_LOW)) u_pd_qual (
    .clk      (clk),
    .rst      (rst),
    .pwr_n    (pwr_n),
    .rel_ok   (rel_ok),
    .rel_short(rel_short)
  );

  always_comb begin
    state_nxt = state;
    case (state)
      ST_RUN:    if (!pwr_n) state_nxt = ST_PD;
      ST_PD:     if (pwr_n) state_nxt = (rel_ok && !cal_dis) ? ST_CAL : ST_RUN;
      ST_CAL:    if (!pwr_n) state_nxt = ST_PD;
                 else if (smp_vld && smp_cnt == CNT_LAST) state_nxt = ST_SETTLE;
      ST_SETTLE: if (!pwr_n) state_nxt = ST_PD;
                 else if (smp_vld) state_nxt = ST_RUN;
      default:   state_nxt = ST_RUN;
    endcase
  end

  assign acc_clr  = (state == ST_PD);
  assign acc_add  = (state == ST_CAL) && pwr_n && smp_vld;
  assign acc_last = (smp_cnt == CNT_LAST);
  assign off_clr  = (state == ST_PD) && rel_ok && cal_dis;
  assign pass     = (state == ST_RUN) && pwr_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_RUN;
      smp_cnt  <= '0;
      blank    <= 1'b0;
      cal_busy <= 1'b0;
      out_vld  <= 1'b0;
    end else begin
      state    <= state_nxt;
      blank    <= (state_nxt != ST_RUN);
      cal_busy <= (state_nxt == ST_CAL);
      out_vld  <= pass && smp_vld;
      if (acc_clr) begin
        smp_cnt <= '0;
      end else if (acc_add) begin
        smp_cnt <= smp_cnt + 1'b1;
      end
    end
  end

  assign din_ch[0] = in_left;
  assign din_ch[1] = in_right;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    ocs_ch_accum #(
      .DATA_W  (DATA_W),
      .ACC_W   (ACC_W),
      .CAL_LOG2(CAL_LOG2)
    ) u_accum (
      .clk    (clk),
      .rst    (rst),
      .clr    (acc_clr),
      .add    (acc_add),
      .last   (acc_last),
      .clr_off(off_clr),
      .din    (din_ch[ch]),
      .offset (off_ch[ch])
    );

    ocs_ch_correct #(.DATA_W(DATA_W)) u_correct (
      .clk    (clk),
      .rst    (rst),
      .pass   (pass),
      .smp_vld(smp_vld),
      .din    (din_ch[ch]),
      .offset (off_ch[ch]),
      .dout   (dout_ch[ch])
    );
  end

  assign out_left  = dout_ch[0];
  assign out_right = dout_ch[1];

  // R2: a low power-down input blanks on the next edge
  a_r2_blank_fast: assert property (@(posedge clk) disable iff (rst)
    !pwr_n |=> blank);
  // R2: nothing is emitted while blanked
  a_r2_no_vld_blanked: assert property (@(posedge clk) disable iff (rst)
    blank |-> !out_vld);
  // R3: busy implies blanking
  a_r3_busy_blanks: assert property (@(posedge clk) disable iff (rst)
    cal_busy |-> blank);
  // R8: a short pulse never starts calibration
  a_r8_short_no_cal: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PD && rel_short) |=> !cal_busy);
  // R9: disabled calibration never raises busy on release
  a_r9_disabled_no_busy: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PD && pwr_n && cal_dis) |=> !cal_busy);
endmodule

// File: tb/offset_cal_seq_tb_top.sv
module offset_cal_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 20;
  localparam int CAL_LOG2   = 4;
  localparam int CAL_N      = 1 << CAL_LOG2;
  localparam int MAXV       = (1 << (DATA_W-1)) - 1;
  localparam int MINV       = -(1 << (DATA_W-1));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_n = 1'b1;
  logic cal_dis = 1'b0;
  logic smp_vld = 1'b0;
  logic signed [DATA_W-1:0] in_left = '0, in_right = '0;
  logic signed [DATA_W-1:0] out_left, out_right;
  logic out_vld, cal_busy, blank;

  int n_checks = 0;
  int n_fail   = 0;
  int off_l    = 0;
  int off_r    = 0;
  int exp_l[$];
  int exp_r[$];
  string exp_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  offset_cal_seq #(
    .DATA_W  (DATA_W),
    .ACC_W   (32),
    .CAL_LOG2(CAL_LOG2),
    .MIN_LOW (2)
  ) dut_i (
    .clk      (clk),
    .rst      (rst),
    .pwr_n    (pwr_n),
    .cal_dis  (cal_dis),
    .smp_vld  (smp_vld),
    .in_left  (in_left),
    .in_right (in_right),
    .out_left (out_left),
    .out_right(out_right),
    .out_vld  (out_vld),
    .cal_busy (cal_busy),
    .blank    (blank)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  // driver: one sample period is four clocks
  task automatic send(input int l, input int r, input bit expect_out, input string tag);
    @(negedge clk);
    in_left  = DATA_W'(l);
    in_right = DATA_W'(r);
    smp_vld  = 1'b1;
    if (expect_out) begin
      exp_l.push_back(sat(l - off_l));
      exp_r.push_back(sat(r - off_r));
      exp_tag.push_back(tag);
    end
    @(negedge clk);
    smp_vld = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // monitor: compare each output pair against the scoreboard
  always @(negedge clk) begin
    if (!rst && out_vld) begin
      if (exp_l.size() == 0) begin
        chk(1'b0, "R2/R4 unexpected out_vld", 1, 0);
      end else begin
        int el, er;
        string t;
        el = exp_l.pop_front();
        er = exp_r.pop_front();
        t  = exp_tag.pop_front();
        chk(int'(out_left) == el, {t, " left"}, int'(out_left), el);
        chk(int'(out_right) == er, {t, " right"}, int'(out_right), er);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(blank == 1'b0, "R1 blank", blank, 0);
    chk(cal_busy == 1'b0, "R1 cal_busy", cal_busy, 0);
    chk(out_vld == 1'b0, "R1 out_vld", out_vld, 0);
    chk(out_left == '0 && out_right == '0, "R1 outputs", int'(out_left), 0);

    // R1/R6 pass-through with zero offset
    send(1234, -77, 1, "R1 R6 passthrough");
    send(MAXV, MINV, 1, "R6 full scale");
    send(0, 5, 1, "R6 small");

    // R2 power-down entry, samples ignored
    @(negedge clk);
    pwr_n = 1'b0;
    @(negedge clk);
    chk(blank == 1'b1, "R2 blank after low", blank, 1);
    send(999, 999, 0, "R2");
    chk(out_left == '0 && out_right == '0, "R2 outputs zero", int'(out_left), 0);
    // R3 release starts calibration
    @(negedge clk);
    pwr_n = 1'b1;
    @(negedge clk);
    chk(cal_busy == 1'b1, "R3 busy on release", cal_busy, 1);
    for (int i = 0; i < CAL_N; i++) begin
      chk(cal_busy == 1'b1 && blank == 1'b1, "R3 busy held", cal_busy, 1);
      send(100 + i, -50 - i, 0, "R3");
    end
    // R4 settle period
    chk(cal_busy == 1'b0, "R4 busy dropped", cal_busy, 0);
    chk(blank == 1'b1, "R4 blank during settle", blank, 1);
    send(7, 7, 0, "R4");
    chk(blank == 1'b0, "R4 blank released", blank, 0);
    // R5 averages: 1720>>>4 = 107, -920>>>4 = -58
    off_l = 107;
    off_r = -58;
    send(1000, 0, 1, "R4 R5 R6 corrected");
    send(-3, 58, 1, "R5 R6 corrected");
    // R7 saturation
    send(MINV, MAXV, 1, "R7 clamp");
    send(MINV + 107, MAXV - 58, 1, "R7 edge no clamp");

    // R8 short pulse keeps offsets
    @(negedge clk);
    pwr_n = 1'b0;
    @(negedge clk);
    pwr_n = 1'b1;
    @(negedge clk);
    chk(cal_busy == 1'b0, "R8 no busy", cal_busy, 0);
    @(negedge clk);
    chk(blank == 1'b0, "R8 back to run", blank, 0);
    send(500, 500, 1, "R8 offsets kept");

    // R9 calibration disabled clears offsets
    cal_dis = 1'b1;
    @(negedge clk);
    pwr_n = 1'b0;
    repeat (3) @(negedge clk);
    pwr_n = 1'b1;
    @(negedge clk);
    chk(cal_busy == 1'b0, "R9 no busy", cal_busy, 0);
    chk(blank == 1'b0, "R9 direct run", blank, 0);
    off_l = 0;
    off_r = 0;
    send(321, -321, 1, "R9 offsets cleared");

    repeat (4) @(negedge clk);
    chk(exp_l.size() == 0, "R6 all outputs seen", exp_l.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule